// File: doc/BRIEF.md
# Linked Command Register Loader

This block walks a chain of commands held in memory and uses them to program a transfer channel's register file. Each command opens with a 32-bit header word. The header is a bitmap: each meaningful set bit names one channel register. The data words for those registers follow the header back to back, lowest bit number first. The memory holds no slot for a register whose bit is clear. The loader fetches the header and then the data words over a single-word read port. It issues one register write strobe for each data word, and the strobe carries the register number and the word.

The loader pulses a channel start once every flagged register has been written. It then waits for the channel to report completion. A successful completion with the enable bit (bit 0) set in the captured link address makes the loader fetch the next command from that address, with bit 0 masked off. A cleared enable bit ends the chain, and so does a channel error. A read error during any fetch aborts the chain and raises a sticky link-error flag.

Top module: `cmd_link_loader`

## Requirements
- R1: Payload words are written in ascending order of the set payload bits of the header, one word per bit. The strobe `wr_en_o` is high in the cycle the read port accepts the word, `wr_idx_o` is the bit number and `wr_data_o` is the word.
- R2: Payload bits are 2..12, 14, 19, 20 and 29..31 (mask 0xE0185FFC). Reserved header bits 1, 13, 15..18 and 21..28 are ignored: they consume no word and produce no write.
- R3: Header bit 0 requests a register clear. It consumes no payload word. `clear_o` pulses for one cycle, in the cycle after the header is accepted and before any payload write. The clear also zeroes the captured link address.
- R4: `chan_start_o` is a one-cycle pulse in the cycle after the last payload write. With no payload it comes in the cycle after the header, or after the clear when there is one. It never coincides with a fetch, a write or a clear.
- R5: Words of a command are fetched from consecutive byte addresses in steps of 4, beginning at the command address. The request and the address are held until the read is accepted.
- R6: When `chan_done_i` arrives without `chan_err_i` and bit 0 of the captured link address (register 30 low word, register 31 high word) is 1, the next header is fetched from the link address with bit 0 cleared.
- R7: When the channel completes and link bit 0 is 0, which includes a link word of zero, the loader returns to idle (`busy_o` low) and issues no further fetch.
- R8: When `chan_done_i` arrives with `chan_err_i` high, the chain stops and the loader returns to idle without fetching.
- R9: A read with `rd_err_i` high aborts the chain. The loader goes idle with `link_err_o` high and writes nothing more, and no start is issued. The next `start_i` clears `link_err_o`.
- R10: After reset the loader is idle: `busy_o`, `rd_req_o`, `wr_en_o`, `clear_o`, `chan_start_o` and `link_err_o` are all 0.

States: IDLE (`start_i` goes to FETCH_HDR), FETCH_HDR (accept goes to CLEAR, FETCH_PAY or KICK; error goes to IDLE), CLEAR (goes to FETCH_PAY or KICK), FETCH_PAY (last word goes to KICK; error goes to IDLE), KICK (goes to WAIT_DONE), WAIT_DONE (done with link enabled goes to FETCH_HDR, otherwise IDLE).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a chain at `start_addr_i` (ignored while busy) |
| start_addr_i | input | ADDR_W | Byte address of the first command |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read byte address |
| rd_valid_i | input | 1 | Read accepted; data valid this cycle |
| rd_data_i | input | 32 | Read data |
| rd_err_i | input | 1 | Read error, qualified by `rd_valid_i` |
| wr_en_o | output | 1 | Register write strobe |
| wr_idx_o | output | 5 | Register number (header bit) |
| wr_data_o | output | 32 | Register write data |
| clear_o | output | 1 | Register-file clear pulse |
| chan_start_o | output | 1 | Channel start pulse |
| chan_done_i | input | 1 | Channel completion pulse |
| chan_err_i | input | 1 | Completion with error, qualified by `chan_done_i` |
| busy_o | output | 1 | Not idle |
| link_err_o | output | 1 | Sticky read-error flag |

## Verification
The hardest situation to reach is a clear that lands in the middle of a live chain. A command whose only content is a clear must wipe a link address that an earlier command enabled, or the loader would refetch forever. The bench builds that chain in its memory model: a first command carries only an enabled link to a second command that requests a clear and nothing else. The bench then checks that exactly three reads and two starts occur before idle. Read errors are placed on one chosen word address, which hits the header and the link-word fetch separately.

// File: rtl/cmd_link_pkg.sv
package cmd_link_pkg;
    localparam int HDR_W       = 32;
    localparam int IDX_W       = $clog2(HDR_W);
    localparam int WORD_BYTES  = HDR_W / 8;
    localparam int CLR_BIT     = 0;
    localparam int LINK_LO_IDX = 30;
    localparam int LINK_HI_IDX = 31;
    localparam int LINK_W      = 2 * HDR_W;
    localparam int LINK_EN_BIT = 0;
    // Header bits that carry a payload word.
    localparam logic [HDR_W-1:0] PAY_MASK = 32'hE018_5FFC;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_FETCH_HDR,
        ST_CLEAR,
        ST_FETCH_PAY,
        ST_KICK,
        ST_WAIT_DONE
    } cl_state_e;
endpackage

// File: rtl/cl_lsb_pick.sv
module cl_lsb_pick #(
    parameter int W  = 32,
    parameter int IW = $clog2(W)
) (
    input  logic [W-1:0]  vec_i,
    output logic [IW-1:0] idx_o
);
    always_comb begin
        idx_o = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (vec_i[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/cl_link_reg.sv
module cl_link_reg
    import cmd_link_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              wr_en_i,
    input  logic [IDX_W-1:0]  wr_idx_i,
    input  logic [HDR_W-1:0]  wr_data_i,
    output logic [LINK_W-1:0] link_o
);
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            link_o <= '0;
        end else if (wr_en_i) begin
            for (int h = 0; h < 2; h++) begin
                if (wr_idx_i == IDX_W'(LINK_LO_IDX + h))
                    link_o[h*HDR_W +: HDR_W] <= wr_data_i;
            end
        end
    end
endmodule

// File: rtl/cmd_link_loader.sv
module cmd_link_loader
    import cmd_link_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] start_addr_i,
    output logic              rd_req_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic              rd_valid_i,
    input  logic [HDR_W-1:0]  rd_data_i,
    input  logic              rd_err_i,
    output logic              wr_en_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [HDR_W-1:0]  wr_data_o,
    output logic              clear_o,
    output logic              chan_start_o,
    input  logic              chan_done_i,
    input  logic              chan_err_i,
    output logic              busy_o,
    output logic              link_err_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    cl_state_e          state_q, state_d;
    logic [ADDR_W-1:0]  addr_q, addr_d;
    logic [HDR_W-1:0]   pend_q, pend_d;
    logic               lerr_q, lerr_d;
    logic [IDX_W-1:0]   pick_idx;
    logic [HDR_W-1:0]   pend_rest;
    logic [HDR_W-1:0]   hdr_pay;
    logic [LINK_W-1:0]  link_q;

    cl_lsb_pick #(.W(HDR_W), .IW(IDX_W)) pick_i (
        .vec_i (pend_q),
        .idx_o (pick_idx)
    );

    cl_link_reg link_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clear_o),
        .wr_en_i   (wr_en_o),
        .wr_idx_i  (wr_idx_o),
        .wr_data_i (wr_data_o),
        .link_o    (link_q)
    );

    assign pend_rest = pend_q & ~(HDR_W'(1) << pick_idx);
    assign hdr_pay   = rd_data_i & PAY_MASK;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            pend_q  <= '0;
            lerr_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            addr_q  <= addr_d;
            pend_q  <= pend_d;
            lerr_q  <= lerr_d;
        end
    end

    always_comb begin
        state_d = state_q;
        addr_d  = addr_q;
        pend_d  = pend_q;
        lerr_d  = lerr_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_i) begin
                    addr_d  = start_addr_i;
                    lerr_d  = 1'b0;
                    state_d = ST_FETCH_HDR;
                end
            end
            ST_FETCH_HDR: begin
                if (rd_valid_i) begin
                    if (rd_err_i) begin
                        lerr_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        pend_d = hdr_pay;
                        addr_d = addr_q + STEP;
                        if (rd_data_i[CLR_BIT])  state_d = ST_CLEAR;
                        else if (|hdr_pay)       state_d = ST_FETCH_PAY;
                        else                     state_d = ST_KICK;
                    end
                end
            end
            ST_CLEAR: begin
                state_d = (|pend_q) ? ST_FETCH_PAY : ST_KICK;
            end
            ST_FETCH_PAY: begin
                if (rd_valid_i) begin
                    if (rd_err_i) begin
                        lerr_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else begin
                        pend_d = pend_rest;
                        addr_d = addr_q + STEP;
                        if (pend_rest == '0) state_d = ST_KICK;
                    end
                end
            end
            ST_KICK: begin
                state_d = ST_WAIT_DONE;
            end
            ST_WAIT_DONE: begin
                if (chan_done_i) begin
                    if (!chan_err_i && link_q[LINK_EN_BIT]) begin
                        addr_d  = link_q[ADDR_W-1:0] & ~ADDR_W'(1);
                        state_d = ST_FETCH_HDR;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_comb begin
        rd_req_o     = (state_q == ST_FETCH_HDR) || (state_q == ST_FETCH_PAY);
        rd_addr_o    = addr_q;
        wr_en_o      = (state_q == ST_FETCH_PAY) && rd_valid_i && !rd_err_i;
        wr_idx_o     = pick_idx;
        wr_data_o    = rd_data_i;
        clear_o      = (state_q == ST_CLEAR);
        chan_start_o = (state_q == ST_KICK);
        busy_o       = (state_q != ST_IDLE);
        link_err_o   = lerr_q;
    end
endmodule

// File: rtl/cmd_link_loader_chk.sv
module cmd_link_loader_chk
    import cmd_link_pkg::*;
#(
    parameter int ADDR_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic              rd_req_o,
    input logic [ADDR_W-1:0] rd_addr_o,
    input logic              rd_valid_i,
    input logic              rd_err_i,
    input logic              wr_en_o,
    input logic [IDX_W-1:0]  wr_idx_o,
    input logic              clear_o,
    input logic              chan_start_o,
    input logic              busy_o,
    input logic              link_err_o
);
    // R1: a write only accompanies an accepted, error-free read
    a_r1_write_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> (rd_req_o && rd_valid_i && !rd_err_i));

    // R2: no write ever targets a reserved header bit
    a_r2_idx_not_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en_o |-> PAY_MASK[wr_idx_o]);

    // R3: the clear cycle neither fetches nor writes
    a_r3_clear_alone: assert property (@(posedge clk) disable iff (!rst_n)
        clear_o |-> (!rd_req_o && !wr_en_o));

    // R4: start is a lone single-cycle pulse
    a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start_o |=> !chan_start_o);
    a_r4_start_alone: assert property (@(posedge clk) disable iff (!rst_n)
        chan_start_o |-> (!rd_req_o && !wr_en_o && !clear_o));

    // R5: an unaccepted request keeps its address
    a_r5_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && !rd_valid_i) |=> (rd_req_o && $stable(rd_addr_o)));

    // R9: a read error ends the chain with the flag raised
    a_r9_err_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req_o && rd_valid_i && rd_err_i) |=> (link_err_o && !busy_o));

    // R10: idle means no traffic
    a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> (!rd_req_o && !wr_en_o && !clear_o && !chan_start_o));
endmodule

bind cmd_link_loader cmd_link_loader_chk #(.ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .rd_req_o     (rd_req_o),
    .rd_addr_o    (rd_addr_o),
    .rd_valid_i   (rd_valid_i),
    .rd_err_i     (rd_err_i),
    .wr_en_o      (wr_en_o),
    .wr_idx_o     (wr_idx_o),
    .clear_o      (clear_o),
    .chan_start_o (chan_start_o),
    .busy_o       (busy_o),
    .link_err_o   (link_err_o)
);

// File: tb/cmd_link_loader_tb_top.sv
`timescale 1ns/1ps
module cmd_link_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [63:0] start_addr_i = '0;
    logic        rd_req_o;
    logic [63:0] rd_addr_o;
    logic        rd_valid_i = 1'b0;
    logic [31:0] rd_data_i = '0;
    logic        rd_err_i = 1'b0;
    logic        wr_en_o;
    logic [4:0]  wr_idx_o;
    logic [31:0] wr_data_o;
    logic        clear_o;
    logic        chan_start_o;
    logic        chan_done_i = 1'b0;
    logic        chan_err_i = 1'b0;
    logic        busy_o;
    logic        link_err_o;

    always #5 clk = ~clk;

    cmd_link_loader dut_i (.*);

    logic [31:0] mem [0:63];
    int  err_word = -1;
    bit  done_err = 1'b0;
    int  done_cnt = 0;
    int  cyc = 0;
    int  n_wr, n_rd, n_clr, n_start;
    int  wr_i [0:127];
    logic [31:0] wr_d [0:127];
    int  wr_c [0:127];
    longint rd_a [0:127];
    int  clr_c, start_c;
    int  e_n;
    int  e_i [0:127];
    logic [31:0] e_d [0:127];
    int  checks = 0, fails = 0;
    localparam logic [31:0] PAYBITS = 32'hE018_5FFC;

    // memory and channel model: inputs change at negedge, outputs read 2 ns later
    always begin
        @(negedge clk);
        cyc++;
        rd_valid_i  = rd_req_o;
        rd_data_i   = mem[rd_addr_o[7:2]];
        rd_err_i    = rd_req_o && (int'(rd_addr_o[7:2]) == err_word);
        chan_done_i = 1'b0;
        chan_err_i  = 1'b0;
        if (done_cnt > 0) begin
            done_cnt--;
            if (done_cnt == 0) begin
                chan_done_i = 1'b1;
                chan_err_i  = done_err;
            end
        end
        #2;
        if (rd_req_o && rd_valid_i && n_rd < 128) begin rd_a[n_rd] = longint'(rd_addr_o); n_rd++; end
        if (wr_en_o && n_wr < 128) begin
            wr_i[n_wr] = int'(wr_idx_o); wr_d[n_wr] = wr_data_o; wr_c[n_wr] = cyc; n_wr++;
        end
        if (clear_o) begin n_clr++; clr_c = cyc; end
        if (chan_start_o) begin n_start++; start_c = cyc; done_cnt = 3; end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic expect_cmd(input int base);
        int p = base + 1;
        for (int b = 1; b < 32; b++) begin
            if (mem[base][b] && PAYBITS[b]) begin
                e_i[e_n] = b; e_d[e_n] = mem[p]; p++; e_n++;
            end
        end
    endtask

    task automatic run(input longint addr);
        int t = 0;
        n_wr = 0; n_rd = 0; n_clr = 0; n_start = 0; clr_c = -1; start_c = -1;
        @(negedge clk); #1 start_addr_i = addr; start_i = 1'b1;
        @(negedge clk); #1 start_i = 1'b0;
        @(negedge clk); #3;
        while (busy_o && t < 500) begin @(negedge clk); #3; t++; end
        chk(t < 500, "R7", "watchdog cycles", t, 0);
    endtask

    task automatic cmp_writes(input string req);
        chk(n_wr == e_n, req, "write count", n_wr, e_n);
        for (int i = 0; i < e_n && i < n_wr; i++) begin
            chk(wr_i[i] == e_i[i], req, "write index", wr_i[i], e_i[i]);
            chk(wr_d[i] == e_d[i], req, "write data", wr_d[i], e_d[i]);
        end
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = '0;
        repeat (3) @(negedge clk);
        #3;
        // R10 reset state
        chk(!busy_o && !rd_req_o && !wr_en_o && !clear_o && !chan_start_o,
            "R10", "idle outputs", {busy_o, rd_req_o, wr_en_o, clear_o, chan_start_o}, 0);
        chk(!link_err_o, "R10", "link_err", link_err_o, 0);
        #1 rst_n = 1'b1;

        // R1 R2 R3 R4 R5 sweep over header patterns
        for (int k = 0; k < 24; k++) begin
            logic [31:0] h;
            int base = (k % 3) * 8;
            int pc;
            int last;
            case (k)
                0: h = 32'h0000_0002;
                1: h = 32'hFFFF_FFFF;
                2: h = 32'h1FE7_A002;
                default: h = (32'(k) * 32'h9E37_79B1) ^ (32'(k) << 7);
            endcase
            if (k >= 3) h[0] = k[0];
            for (int i = 0; i < 64; i++) mem[i] = 32'hC0DE_0000 | (32'(k) << 12) | (32'(i) << 2);
            mem[base] = h;
            e_n = 0; expect_cmd(base);
            pc = $countones(h & PAYBITS);
            run(longint'(base * 4));
            cmp_writes("R1");
            chk(n_rd == pc + 1, "R2", "words fetched", n_rd, pc + 1);
            for (int i = 0; i < n_rd; i++)
                chk(rd_a[i] == longint'(base * 4 + 4 * i), "R5", "fetch address", rd_a[i], base * 4 + 4 * i);
            chk(n_clr == int'(h[0]), "R3", "clear pulses", n_clr, h[0]);
            if (h[0] && n_wr > 0) chk(clr_c < wr_c[0], "R3", "clear before first write", clr_c, wr_c[0]);
            last = (n_wr > 0) ? wr_c[n_wr-1] : (h[0] ? clr_c : start_c - 1);
            chk(n_start == 1 && start_c == last + 1, "R4", "start cycle", start_c, last + 1);
        end

        // R6 R7 two-command chain
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[4]  = 32'h4000_0009; mem[5] = 32'h0000_0011; mem[6] = (32'd40 << 2) | 32'd1;
        mem[40] = 32'h4000_0050; mem[41] = 32'hAAAA_0000; mem[42] = 32'hBBBB_0000; mem[43] = 32'h0;
        e_n = 0; expect_cmd(4); expect_cmd(40);
        run(64'd16);
        cmp_writes("R6");
        chk(n_start == 2, "R6", "starts", n_start, 2);
        chk(n_rd == 7 && rd_a[3] == 160, "R6", "link fetch address", rd_a[3], 160);
        chk(!busy_o && !link_err_o, "R7", "idle after zero link", busy_o, 0);

        // R8 channel error stops chain
        done_err = 1'b1;
        e_n = 0; expect_cmd(4);
        run(64'd16);
        cmp_writes("R8");
        chk(n_start == 1 && n_rd == 3, "R8", "reads after channel error", n_rd, 3);
        done_err = 1'b0;

        // R9 read error on link payload word
        err_word = 6;
        run(64'd16);
        chk(n_wr == 1 && wr_i[0] == 3, "R9", "writes before error", n_wr, 1);
        chk(n_start == 0, "R9", "no start", n_start, 0);
        chk(link_err_o && !busy_o, "R9", "link_err raised", link_err_o, 1);
        // R9 read error on header
        err_word = 40;
        run(64'd16);
        chk(n_wr == 2 && n_start == 1 && link_err_o, "R9", "header error", n_wr, 2);
        // R9 flag cleared by next start
        err_word = -1;
        run(64'd16);
        chk(!link_err_o && n_start == 2, "R9", "flag cleared", link_err_o, 0);

        // R3 clear-only command wipes an enabled link
        for (int i = 0; i < 64; i++) mem[i] = '0;
        mem[50] = 32'h4000_0000; mem[51] = (32'd20 << 2) | 32'd1;
        mem[20] = 32'h0000_0001;
        run(64'd200);
        chk(n_rd == 3 && n_start == 2 && n_clr == 1, "R3", "clear ends chain reads", n_rd, 3);
        chk(n_wr == 1 && wr_i[0] == 30, "R3", "single link write", n_wr, 1);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule